// File: doc/BRIEF.md
# DTMF Tone Steering and Output Latch

This block does the steering job that a resistor-capacitor network does around a tone-pair receiver, using logic only. An upstream frequency detector supplies a per-cycle "tone recognised" flag and a 4-bit candidate code. The block combines that flag with inhibit and power-down into a qualified tone signal, which it shows at once on an early-detect output. Guard timing is counted in ticks of a slow enable, normally one tick per millisecond. A tone that stays qualified for `GUARD_ON` ticks is registered, and a silence that lasts `GUARD_OFF` ticks frees the block to take the next digit.

When a tone is registered, its code is loaded into a 4-bit latch. One clock later a delayed strobe rises, so the data is already stable when the strobe appears. The latch keeps the last registered code through pauses. It drives a three-state bus under an output enable, and a separate per-bit enable is also provided for synthesis. The upstream detector chooses the code values. The usual mapping is: digits 1 to 9 as themselves, 0 as 10, `*` as 11, `#` as 12, A to C as 13 to 15, and D as 0.

With the default of 30 ticks for both guards, a tone or pause of 40 ms or more is always accepted, and one shorter than 20 ms is always ignored.

Top module: `tone_steer`

## Requirements
- R1: `early` is high in exactly the cycles where `tone_det` is high and `inhibit`, `pwr_down` and `rst` are all low. It has no register delay.
- R2: A qualified tone is registered only if it stays unbroken through `GUARD_ON` tick edges, counted from the clock edge after it starts. A shorter tone leaves `q` and `strobe` unchanged.
- R3: While a tone is registered, a qualified-tone gap that spans `GUARD_OFF` tick edges returns the block to idle. A shorter gap is ignored: the tone that follows does not update the latch again.
- R4: The latch is loaded from `code_in` once per registered tone, at the edge where the guard completes. It keeps that value through pauses and rejected tones until the next registration.
- R5: `strobe` rises one clock after the latch update. It falls one clock after the block returns to idle.
- R6: With `out_en` high, `q` drives the latch value and `q_oe` is 4'b1111. With `out_en` low, `q` is 4'bzzzz and `q_oe` is 4'b0000.
- R7: While `inhibit` is high, tones are neither detected nor registered.
- R8: While `pwr_down` is high, the block is held idle with its guard counter cleared. From the next edge `strobe` is low, and the latch keeps its value.
- R9: A synchronous active-high `rst` clears the latch to 0, forces `strobe` and `early` low and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Guard-time enable, one cycle per tick |
| tone_det | input | 1 | Detector flag: recognisable tone pair present |
| code_in | input | 4 | Candidate code from the detector |
| inhibit | input | 1 | High blocks tone detection |
| pwr_down | input | 1 | High holds the block idle |
| out_en | input | 1 | Drives the data bus when high |
| early | output | 1 | Early-detect steering output |
| strobe | output | 1 | Delayed steering output |
| q_oe | output | 4 | Per-bit output enable for the data bus |
| q | output | 4 | Three-state latched code |

## Verification
The bench uses small guards (4 ticks on, 3 off) and runs every tone length from 1 to 6 ticks against every gap length from 1 to 5 ticks, each with its own code. This separates tones one tick short of the guard from tones that just reach it, and separates gaps that release the latch from gaps that are bridged without a second update. Further patterns cover a long tone held under inhibit, power-down applied while a code is registered, the bus turned off and on, and a tone held during reset. Each pattern distinguishes an early or late guard, a repeated latch load, or a missing gate term.

// File: rtl/tone_steer.sv
module tone_steer #(
  parameter int GUARD_ON  = 30,
  parameter int GUARD_OFF = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       tone_det,
  input  logic [3:0] code_in,
  input  logic       inhibit,
  input  logic       pwr_down,
  input  logic       out_en,
  output logic       early,
  output logic       strobe,
  output logic [3:0] q_oe,
  output logic [3:0] q
);
  localparam int GMAX = (GUARD_ON > GUARD_OFF) ? GUARD_ON : GUARD_OFF;
  localparam int CW   = $clog2(GMAX + 1);

  logic          valid, valid_q, steady, held, upd, rel;
  logic [CW-1:0] cnt;
  logic [3:0]    lat;

  assign valid  = tone_det & ~inhibit & ~pwr_down & ~rst;
  assign early  = valid;
  assign steady = (valid == valid_q);
  assign upd    = !held &&  valid && steady && tick && cnt == CW'(GUARD_ON - 1);
  assign rel    =  held && !valid && steady && tick && cnt == CW'(GUARD_OFF - 1);

  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      valid_q <= 1'b0;
      cnt     <= '0;
      held    <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      valid_q <= valid;
      if (!steady)                             cnt <= '0;
      else if (tick && cnt != CW'(GMAX))       cnt <= cnt + 1'b1;
      if (upd)      held <= 1'b1;
      else if (rel) held <= 1'b0;
      strobe <= held;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      lat <= 4'h0;
    else if (upd) lat <= code_in;
  end

  assign q_oe = {4{out_en}};
  assign q    = out_en ? lat : 4'bzzzz;

  // R5: strobe follows a registration one clock later
  a_r5_strobe_after_load: assert property (@(posedge clk) disable iff (rst || pwr_down)
    upd |=> (held && !strobe) ##1 strobe);
  // R4: latch only moves on a registration
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(lat));
  // R2: a registration needs a tone unbroken since the previous edge
  a_r2_needs_steady_tone: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(tone_det && !inhibit && valid_q));
  // R7: inhibit blocks registration
  a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !$rose(held));
  // R8: power-down leaves the block idle and cleared
  a_r8_pd_idle: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!held && !strobe && cnt == '0));
  // R3: release only after a stretch with no qualified tone
  a_r3_release_on_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(held) && !$past(pwr_down)) |-> !$past(valid) && !$past(valid_q));
endmodule

// File: tb/tone_steer_tb.sv
module tone_steer_tb_top;
  localparam int ON  = 4;
  localparam int OFF = 3;

  logic clk = 0, rst = 1, tick = 0, tone_det = 0, inhibit = 0, pwr_down = 0, out_en = 1;
  logic [3:0] code_in = 0;
  logic early, strobe;
  logic [3:0] q_oe;
  wire  [3:0] q;
  int   ph = 0, nchk = 0, nfail = 0;
  logic m_held = 0;
  logic [3:0] m_lat = 0;

  tone_steer #(.GUARD_ON(ON), .GUARD_OFF(OFF)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .tone_det(tone_det), .code_in(code_in),
    .inhibit(inhibit), .pwr_down(pwr_down), .out_en(out_en),
    .early(early), .strobe(strobe), .q_oe(q_oe), .q(q));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tick <= (ph == 3);
    ph   <= (ph + 1) % 4;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick) k++;
    end
  endtask

  task automatic seg(input bit lvl, input logic [3:0] code, input int n, input string req);
    @(negedge clk);
    tone_det = lvl;
    code_in  = code;
    #1 chk(early == (lvl & ~inhibit), "R1 early", early, lvl & ~inhibit);
    wait_ticks(n);
    if (lvl && !inhibit) begin
      if (!m_held && n >= ON) begin m_held = 1; m_lat = code; end
    end else if (m_held && n >= OFF) m_held = 0;
    @(posedge clk);
    @(negedge clk);
    chk(q === m_lat, req, q, m_lat);
    chk(strobe == m_held, "R5 strobe", strobe, m_held);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tone_det = 1;
    code_in  = 4'h7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(early == 0, "R9 early in reset", early, 0);
    chk(q === 4'h0, "R9 latch cleared", q, 0);
    chk(strobe == 0, "R9 strobe low", strobe, 0);
    tone_det = 0;
    rst = 0;
    repeat (2) @(negedge clk);

    // R2 R3 R4: sweep tone length against gap length
    for (int d = 1; d <= ON + 2; d++)
      for (int g = 1; g <= OFF + 2; g++) begin
        seg(1, 4'((d * 5 + g * 3) & 15), d, "R2 tone accept/reject");
        seg(0, 4'h0, g, "R3 gap");
        seg(1, 4'((d + g) & 15), 1, "R4 single load per tone");
        seg(0, 4'h0, OFF + 1, "R4 hold through pause");
      end

    // R7: long tone under inhibit
    inhibit = 1;
    seg(1, 4'h9, ON + 3, "R7 inhibit");
    inhibit = 0;
    seg(0, 4'h0, OFF, "R7 after inhibit");

    // R8: power-down while registered
    seg(1, 4'hC, ON, "R8 setup");
    chk(strobe == 1, "R8 registered before power-down", strobe, 1);
    @(negedge clk);
    pwr_down = 1;
    #1 chk(early == 0, "R8 early gated", early, 0);
    @(posedge clk);
    @(negedge clk);
    chk(strobe == 0, "R8 strobe low", strobe, 0);
    chk(q === 4'hC, "R8 latch kept", q, 12);
    tone_det = 0;
    @(negedge clk);
    pwr_down = 0;
    m_held = 0;
    seg(0, 4'h0, OFF, "R8 after power-down");

    // R6: bus enable
    @(negedge clk);
    out_en = 0;
    #1 chk(q === 4'bzzzz, "R6 bus released", q, 0);
    chk(q_oe == 4'b0000, "R6 oe low", q_oe, 0);
    out_en = 1;
    #1 chk(q === 4'hC, "R6 bus driven", q, 12);
    chk(q_oe == 4'b1111, "R6 oe high", q_oe, 15);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule